// File: doc/BRIEF.md
# UART Receive Break Detector

This block sits next to a UART receiver and decides when the receive line is in a break condition. The receiver feeds it the sampled line level, a strobe once per bit time, a strobe when a character has been framed (with a flag saying its stop bit was wrong), and the byte it assembled. A break is only declared when a character with a bad stop bit is followed by the line staying at space (0) for a whole frame's worth of bit times. The frame length is worked out from the character format: one start bit, five to eight data bits, an optional parity bit and one or two stop bits.

Once a break is declared the block raises a sticky status flag and closes a gate that keeps the all-zero characters the receiver keeps framing out of the receive FIFO. When the line goes back to mark (1) the gate opens again on its own, but the flag stays set until software clears it. To clear it, software reads the flag while it is 1 and then writes 0. An asynchronous power-on reset and a synchronous manual reset both clear everything.

The controller has three states. IDLE: watching for a bad frame. ARMED: a bad frame was seen and space bit times are being counted. BREAK: a break is active. There are five transitions. IDLE goes to ARMED when a framing-error frame ends with the line at 0. ARMED goes to IDLE when the line is seen at 1. ARMED goes to BREAK on the bit strobe that completes a frame length of space. BREAK goes to IDLE when the line is seen at 1. Either reset sends any state to IDLE.

Top module: `uart_break_detector`

## Requirements
- R1: Frame length in bit times is 1 + (5 + cfg_data_code) + cfg_parity_en + (1 + cfg_two_stop), with cfg_data_code 0..3 selecting 5..8 data bits. For example, 8N1 (code 3, no parity, one stop) gives 10 and 5N1 gives 7.
- R2: After a frame_done with frame_err while rx_line is 0, brk_flag rises on the clock edge that samples the frame-length-th bit_tick with rx_line still 0.
- R3: If rx_line is sampled at 1 before that count is reached, the count is discarded and no flag is set. Later space without a new framing error does not set it either.
- R4: While the break is active, rx_store_en is 0 and a frame_done carrying rx_byte 0x00 does not assert fifo_wr. Outside the break, fifo_wr equals frame_done in the same cycle.
- R5: A break ends on the first edge that samples rx_line at 1. rx_store_en returns to 1 while brk_flag stays set.
- R6: An sts_rd while brk_flag is 1, followed later by an sts_wr with sts_wr_bit 0, clears brk_flag on that write's edge.
- R7: An sts_wr with sts_wr_bit 0 and no read of the flag as 1 since the last write is ignored. An sts_wr with sts_wr_bit 1 never changes brk_flag.
- R8: rst_n (asynchronous, active low) and soft_rst (synchronous, active high) both clear brk_flag and return to IDLE with rx_store_en 1.
- R9: A frame_done without frame_err does not arm the detector, however long the line then stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Manual reset, synchronous, active high |
| cfg_data_code | input | 2 | Data bits minus 5 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_two_stop | input | 1 | Two stop bits |
| rx_line | input | 1 | Sampled receive line level |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| frame_done | input | 1 | One-cycle strobe when a character is framed |
| frame_err | input | 1 | Framed character had a bad stop bit |
| rx_byte | input | 8 | Received character |
| sts_rd | input | 1 | Status register read strobe |
| sts_wr | input | 1 | Status register write strobe |
| sts_wr_bit | input | 1 | Value written to the break flag |
| brk_flag | output | 1 | Sticky break status flag |
| rx_store_en | output | 1 | 0 while a break is active |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |

## Verification
The assertions assume that bit_tick, frame_done and the status strobes are single-cycle pulses, and that the character format does not change while the detector is ARMED. The bench changes cfg_* only between trials, after the line has returned to mark and the detector is back in IDLE. It drives each strobe for exactly one cycle, with idle cycles between bit ticks. Random trials draw the format and the space length around the frame-length boundary. Directed cases cover short space followed by mark, frames without an error, and the clear handshake done out of order.

// File: rtl/ubd_pkg.sv
package ubd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BREAK = 2'd2
    } brk_state_t;
endpackage

// File: rtl/ubd_frame_len.sv
module ubd_frame_len #(
    parameter int MIN_DATA = 5,
    parameter int CODE_W   = 2,
    parameter int CNT_W    = 4
) (
    input  logic [CODE_W-1:0] data_code,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic [CNT_W-1:0]  frame_len
);
    localparam logic [CNT_W-1:0] FIXED_BITS = CNT_W'(MIN_DATA + 2); // start + min data + one stop

    always_comb begin
        frame_len = FIXED_BITS
                  + CNT_W'(data_code)
                  + CNT_W'(parity_en)
                  + CNT_W'(two_stop);
    end
endmodule

// File: rtl/ubd_space_fsm.sv
module ubd_space_fsm
    import ubd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             rx_line,
    input  logic             bit_tick,
    input  logic             frame_done,
    input  logic             frame_err,
    output logic             brk_set,
    output logic             brk_active
);
    brk_state_t       state, state_nx;
    logic [CNT_W-1:0] space_cnt, space_cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            space_cnt <= '0;
        end else if (soft_rst) begin
            state     <= ST_IDLE;
            space_cnt <= '0;
        end else begin
            state     <= state_nx;
            space_cnt <= space_cnt_nx;
        end
    end

    // Next state and counter
    always_comb begin
        state_nx     = state;
        space_cnt_nx = space_cnt;
        unique case (state)
            ST_IDLE: begin
                if (frame_done && frame_err && !rx_line) begin
                    state_nx     = ST_ARMED;
                    space_cnt_nx = '0;
                end
            end
            ST_ARMED: begin
                if (rx_line) begin
                    state_nx     = ST_IDLE;
                    space_cnt_nx = '0;
                end else if (bit_tick) begin
                    if (space_cnt == frame_len - CNT_W'(1)) begin
                        state_nx     = ST_BREAK;
                        space_cnt_nx = '0;
                    end else begin
                        space_cnt_nx = space_cnt + CNT_W'(1);
                    end
                end
            end
            ST_BREAK: begin
                if (rx_line) state_nx = ST_IDLE;
            end
            default: begin
                state_nx     = ST_IDLE;
                space_cnt_nx = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        brk_active = (state == ST_BREAK);
        brk_set    = (state == ST_ARMED) && !rx_line && bit_tick
                     && (space_cnt == frame_len - CNT_W'(1));
    end

    a_r3_mark_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && rx_line) |=> (state == ST_IDLE));

    a_r5_mark_ends_break: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK && rx_line) |=> (state == ST_IDLE));

    a_r9_clean_frame_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(frame_done && frame_err)) |=> (state == ST_IDLE));

    a_r8_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == ST_IDLE));
endmodule

// File: rtl/ubd_flag_ctl.sv
module ubd_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic brk_set,
    input  logic sts_rd,
    input  logic sts_wr,
    input  logic sts_wr_bit,
    output logic brk_flag
);
    logic rd_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_flag <= 1'b0;
            rd_seen  <= 1'b0;
        end else if (soft_rst) begin
            brk_flag <= 1'b0;
            rd_seen  <= 1'b0;
        end else begin
            if (brk_set)
                brk_flag <= 1'b1;
            else if (sts_wr && !sts_wr_bit && rd_seen)
                brk_flag <= 1'b0;

            if (sts_wr)
                rd_seen <= 1'b0;
            else if (sts_rd && brk_flag)
                rd_seen <= 1'b1;
        end
    end

    a_r7_no_clear_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !rd_seen && !soft_rst) |=> brk_flag);

    a_r6_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !sts_wr_bit && rd_seen && !brk_set) |=> !brk_flag);

    a_r8_soft_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !brk_flag);
endmodule

// File: rtl/uart_break_detector.sv
module uart_break_detector #(
    parameter int DATA_W   = 8,
    parameter int MIN_DATA = 5,
    parameter int CODE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [CODE_W-1:0] cfg_data_code,
    input  logic              cfg_parity_en,
    input  logic              cfg_two_stop,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic              frame_done,
    input  logic              frame_err,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              sts_rd,
    input  logic              sts_wr,
    input  logic              sts_wr_bit,
    output logic              brk_flag,
    output logic              rx_store_en,
    output logic              fifo_wr
);
    localparam int FRAME_MAX = 1 + MIN_DATA + (2 ** CODE_W - 1) + 1 + 2;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    logic [CNT_W-1:0] frame_len;
    logic             brk_set;
    logic             brk_active;

    ubd_frame_len #(.MIN_DATA(MIN_DATA), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_len (
        .data_code (cfg_data_code),
        .parity_en (cfg_parity_en),
        .two_stop  (cfg_two_stop),
        .frame_len (frame_len)
    );

    ubd_space_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .frame_len  (frame_len),
        .rx_line    (rx_line),
        .bit_tick   (bit_tick),
        .frame_done (frame_done),
        .frame_err  (frame_err),
        .brk_set    (brk_set),
        .brk_active (brk_active)
    );

    ubd_flag_ctl u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .brk_set    (brk_set),
        .sts_rd     (sts_rd),
        .sts_wr     (sts_wr),
        .sts_wr_bit (sts_wr_bit),
        .brk_flag   (brk_flag)
    );

    always_comb begin
        rx_store_en = !brk_active;
        fifo_wr     = frame_done && (rx_store_en || (rx_byte != '0));
    end

    a_r4_zero_blocked_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_store_en && frame_done && rx_byte == '0) |-> !fifo_wr);

    a_r4_store_outside_break: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store_en && frame_done) |-> fifo_wr);

    a_r2_flag_rises_with_break: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> !rx_store_en);

    a_r8_soft_reset_opens_gate: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> rx_store_en);
endmodule

// File: tb/uart_break_detector_tb.sv
module uart_break_detector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [1:0] cfg_data_code = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rx_line = 1'b1;
    logic       bit_tick = 1'b0;
    logic       frame_done = 1'b0;
    logic       frame_err = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       sts_rd = 1'b0;
    logic       sts_wr = 1'b0;
    logic       sts_wr_bit = 1'b0;
    logic       brk_flag, rx_store_en, fifo_wr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_break_detector u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_data_code(cfg_data_code), .cfg_parity_en(cfg_parity_en),
        .cfg_two_stop(cfg_two_stop), .rx_line(rx_line), .bit_tick(bit_tick),
        .frame_done(frame_done), .frame_err(frame_err), .rx_byte(rx_byte),
        .sts_rd(sts_rd), .sts_wr(sts_wr), .sts_wr_bit(sts_wr_bit),
        .brk_flag(brk_flag), .rx_store_en(rx_store_en), .fifo_wr(fifo_wr)
    );

    // R1 model
    function automatic int frame_bits(input int code, input int par, input int two);
        return 1 + (5 + code) + par + (1 + two);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_space(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Framing-error frame with line at 0; fifo_wr checked combinationally
    task automatic bad_frame(input string req, input int exp_wr);
        @(negedge clk);
        rx_line = 1'b0; frame_done = 1'b1; frame_err = 1'b1; rx_byte = 8'h00;
        #1 check(req, fifo_wr, exp_wr);
        @(negedge clk);
        frame_done = 1'b0; frame_err = 1'b0;
    endtask

    task automatic go_mark;
        @(negedge clk) rx_line = 1'b1;
        @(negedge clk);
    endtask

    task automatic sw_read;
        @(negedge clk) sts_rd = 1'b1;
        @(negedge clk) sts_rd = 1'b0;
    endtask

    task automatic sw_write(input logic v);
        @(negedge clk) begin sts_wr = 1'b1; sts_wr_bit = v; end
        @(negedge clk) sts_wr = 1'b0;
    endtask

    task automatic pulse_soft_rst;
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int fl;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R8: power-on reset state
        check("R8 reset flag", brk_flag, 0);
        check("R8 reset gate", rx_store_en, 1);
        check("R8 reset fifo_wr", fifo_wr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: 8N1 boundary, 9 ticks no flag, 10th sets it
        fl = frame_bits(3, 0, 0);
        check("R1 8N1 length", fl, 10);
        bad_frame("R4 store bad frame", 1);
        tick_space(fl - 1);
        check("R2 one short of frame", brk_flag, 0);
        tick_space(1);
        check("R2 full frame sets flag", brk_flag, 1);
        check("R4 gate closed", rx_store_en, 0);
        // R4: zero byte blocked during break
        @(negedge clk) begin frame_done = 1'b1; rx_byte = 8'h00; end
        #1 check("R4 zero byte suppressed", fifo_wr, 0);
        @(negedge clk) frame_done = 1'b0;
        // R5: mark ends break, flag sticks
        go_mark;
        check("R5 gate reopens", rx_store_en, 1);
        check("R5 flag stays", brk_flag, 1);
        @(negedge clk) frame_done = 1'b1;
        #1 check("R4 store resumes", fifo_wr, 1);
        @(negedge clk) frame_done = 1'b0;
        // R7: write 0 without read ignored, write 1 ignored
        sw_write(1'b0);
        check("R7 write0 no read", brk_flag, 1);
        sw_read;
        sw_write(1'b1);
        check("R7 write1 ignored", brk_flag, 1);
        sw_write(1'b0);
        check("R7 read consumed by write", brk_flag, 1);
        // R6: proper clear
        sw_read;
        sw_write(1'b0);
        check("R6 read then write0 clears", brk_flag, 0);

        // R1: 5N1 and 8P2 boundaries
        cfg_data_code = 2'd0;
        fl = frame_bits(0, 0, 0);
        check("R1 5N1 length", fl, 7);
        bad_frame("R4 store bad frame", 1);
        tick_space(fl - 1);
        check("R1 5N1 short", brk_flag, 0);
        tick_space(1);
        check("R1 5N1 sets", brk_flag, 1);
        go_mark;
        sw_read; sw_write(1'b0);
        cfg_data_code = 2'd3; cfg_parity_en = 1'b1; cfg_two_stop = 1'b1;
        fl = frame_bits(3, 1, 1);
        check("R1 8P2 length", fl, 12);
        bad_frame("R4 store bad frame", 1);
        tick_space(fl - 1);
        check("R1 8P2 short", brk_flag, 0);
        tick_space(1);
        check("R1 8P2 sets", brk_flag, 1);
        // R8: soft reset during break
        pulse_soft_rst;
        check("R8 soft reset flag", brk_flag, 0);
        check("R8 soft reset gate", rx_store_en, 1);
        go_mark;

        // R3: short space, mark, more space without new error
        bad_frame("R4 store bad frame", 1);
        tick_space(fl - 1);
        go_mark;
        @(negedge clk) rx_line = 1'b0;
        tick_space(fl + 2);
        check("R3 disarmed by mark", brk_flag, 0);
        check("R3 gate open", rx_store_en, 1);
        go_mark;

        // R9: clean frame, long space
        @(negedge clk) begin rx_line = 1'b0; frame_done = 1'b1; frame_err = 1'b0; end
        @(negedge clk) frame_done = 1'b0;
        tick_space(fl + 2);
        check("R9 clean frame no arm", brk_flag, 0);
        go_mark;

        // Random trials around the boundary
        for (int t = 0; t < 60; t++) begin
            int code, par, two, len;
            bit brk;
            code = int'($urandom_range(3, 0));
            par  = int'($urandom_range(1, 0));
            two  = int'($urandom_range(1, 0));
            cfg_data_code = code[1:0]; cfg_parity_en = par[0]; cfg_two_stop = two[0];
            fl  = frame_bits(code, par, two);
            len = int'($urandom_range(fl + 2, fl - 3));
            brk = (len >= fl);
            bad_frame("R4 random bad frame stored", 1);
            tick_space(len);
            check("R2 random flag", brk_flag, int'(brk));
            check("R4 random gate", rx_store_en, int'(!brk));
            @(negedge clk) begin frame_done = 1'b1; frame_err = 1'b1; rx_byte = 8'h00; end
            #1 check("R4 random zero byte", fifo_wr, int'(!brk));
            @(negedge clk) begin frame_done = 1'b0; frame_err = 1'b0; end
            go_mark;
            check("R5 random gate after mark", rx_store_en, 1);
            check("R5 random flag after mark", brk_flag, int'(brk));
            if (brk) begin
                if ($urandom_range(1, 0) == 1) begin
                    sw_write(1'b0);
                    check("R7 random write0 no read", brk_flag, 1);
                end
                sw_read;
                sw_write(1'b0);
                check("R6 random clear", brk_flag, 0);
            end
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule